// File: doc/BRIEF.md
# Serial-Peripheral EEPROM Emulator

This block is an SPI slave that behaves like a small byte-wide serial EEPROM. A host lowers chip select, shifts in an 8-bit instruction most-significant bit first, and then depending on the instruction shifts address and data bytes in or reads bytes out. Storage is an on-chip register file whose depth is a parameter from 128 to 512 bytes. A write-enable latch, two block-protect bits and a busy flag are held in a status byte that the host can read at any time.

The SPI pins are oversampled by the system clock through two-stage synchronizers, so the serial clock must be several times slower than the system clock. Data is taken on the rising serial-clock edge and driven on the falling edge (mode 0). A write or a status write is committed when chip select rises. A programmable countdown then stands in for the non-volatile programming time. While it runs the block reports busy and accepts only status reads.

Top module: `spi_eeprom_emu`

## Requirements
- R1: After reset the status byte reads 0x00. Its layout is bit 0 busy, bit 1 write-enable latch, bit 2 protect bit 0, bit 3 protect bit 1, and bits 7:4 read as zero.
- R2: An opcode is decoded only when its upper four bits are zero. Bits 2:0 select the instruction: 110 enable writes, 100 disable writes, 101 read status, 001 write status, 011 read array, 010 write array. Bit 3 plays no part in the decode. Any other opcode is ignored until chip select rises.
- R3: The enable instruction sets the write-enable latch only when wp_n is high as its last bit is taken. The disable instruction clears the latch at any wp_n level.
- R4: A write is opcode, address byte, then data byte. The first data byte is stored at the address only if the write-enable latch is set and chip select rises on a byte boundary. In every other case the array and the status byte are left unchanged.
- R5: A read is opcode then address byte. It then returns bytes from consecutive addresses MSB first, wrapping from DEPTH-1 to 0, for as long as chip select stays low.
- R6: When DEPTH exceeds 256, bit 3 of the read and write opcodes is address bit 8.
- R7: Write status loads protect bits 1:0 from bits 3:2 of its data byte. It is gated like an array write and starts the busy period.
- R8: Protect code 00 guards nothing, 01 guards the top quarter, 10 the top half and 11 the whole array. A write to a guarded address is dropped, does not start busy, and leaves the latch set.
- R9: A committed write starts a busy period of BUSY_CYCLES system clocks. During it, status bit 0 reads 1 and every instruction except status read is ignored. At its end, busy and the write-enable latch both clear.
- R10: miso is high-impedance whenever cs_n is high.
- R11: A status read keeps returning the live status byte for every further byte clocked while chip select stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block; high-impedance while deselected |
| wp_n | input | 1 | Active-low write protect, checked by the enable instruction |

## Verification
The bench builds the block with DEPTH=512 and BUSY_CYCLES=1500. The 512-byte depth exercises the ninth address bit carried in the opcode and the read wrap from 511 back to 0. The long busy period leaves enough time for a full status read and a complete write instruction to land inside one programming window, so the bench can show that the second write is dropped. Directed cases cover the protect ranges and an aborted mid-byte write. A seeded random run of writes and streamed reads is checked against a byte-array model.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_CMD, S_RADDR, S_WADDR, S_RDATA,
        S_WDATA, S_SOUT, S_SIN, S_SKIP
    } ee_state_e;

    localparam logic [2:0] OPL_WREN  = 3'b110;
    localparam logic [2:0] OPL_WRDI  = 3'b100;
    localparam logic [2:0] OPL_RDSR  = 3'b101;
    localparam logic [2:0] OPL_WRSR  = 3'b001;
    localparam logic [2:0] OPL_READ  = 3'b011;
    localparam logic [2:0] OPL_WRITE = 3'b010;
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
    parameter int W = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
        end else begin
            chain_q[0] <= din;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/spi_ee_mem.sv
module spi_ee_mem #(
    parameter int DEPTH = 128,
    parameter int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

    // R4
    waddr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(waddr) < DEPTH));
endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
    import spi_ee_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int BUSY_CYCLES = 5000,
    parameter int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          sck_s,
    input  logic          mosi_s,
    input  logic          wp_s,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [7:0]    wdata,
    output logic          miso_bit
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);
    localparam logic [CW-1:0] BUSY_LOAD = CW'(BUSY_CYCLES);
    localparam int QUARTER_START = DEPTH - DEPTH / 4;
    localparam int HALF_START = DEPTH / 2;

    typedef struct packed {
        ee_state_e      st;
        logic           cs_p;
        logic           sck_p;
        logic [2:0]     cnt;
        logic [7:0]     sh;
        logic [7:0]     tx;
        logic           hi;
        logic [AW-1:0]  addr;
        logic [7:0]     dat;
        logic           got;
        logic           wel;
        logic [1:0]     bp;
        logic [CW-1:0]  bcnt;
    } ctrl_t;

    ctrl_t q, d;
    logic busy;
    logic cs_fall, cs_rise, sck_rise, sck_fall;
    logic [7:0] rx_nx, status;

    function automatic logic [AW-1:0] mk_addr(input logic hi, input logic [7:0] lo);
        return AW'({hi, lo});
    endfunction

    function automatic logic is_prot(input logic [1:0] bp, input logic [AW-1:0] a);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return int'(a) >= QUARTER_START;
            2'b10:   return int'(a) >= HALF_START;
            default: return 1'b1;
        endcase
    endfunction

    assign busy     = (q.bcnt != '0);
    assign cs_fall  = q.cs_p && !cs_s;
    assign cs_rise  = !q.cs_p && cs_s;
    assign sck_rise = !q.sck_p && sck_s;
    assign sck_fall = q.sck_p && !sck_s;
    assign rx_nx    = {q.sh[6:0], mosi_s};
    assign status   = {4'b0000, q.bp, q.wel, busy};

    always_comb begin
        d = q;
        we = 1'b0;
        d.cs_p = cs_s;
        d.sck_p = sck_s;
        if (busy) begin
            d.bcnt = q.bcnt - 1'b1;
            if (q.bcnt == CW'(1)) d.wel = 1'b0;
        end
        if (cs_fall) begin
            d.st = S_CMD;
            d.cnt = '0;
            d.got = 1'b0;
        end else if (cs_rise) begin
            d.st = S_IDLE;
            if (q.cnt == '0 && q.got && q.wel && !busy) begin
                if (q.st == S_WDATA && !is_prot(q.bp, q.addr)) begin
                    we = 1'b1;
                    d.bcnt = BUSY_LOAD;
                end else if (q.st == S_SIN) begin
                    d.bp = q.dat[3:2];
                    d.bcnt = BUSY_LOAD;
                end
            end
        end else if (q.st != S_IDLE) begin
            if (sck_rise) begin
                d.sh = rx_nx;
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == 3'd7) begin
                    case (q.st)
                        S_CMD: begin
                            d.st = S_SKIP;
                            d.hi = rx_nx[3];
                            if (rx_nx[7:4] == 4'b0000) begin
                                if (busy) begin
                                    if (rx_nx[2:0] == OPL_RDSR) d.st = S_SOUT;
                                end else begin
                                    case (rx_nx[2:0])
                                        OPL_WREN:  if (wp_s) d.wel = 1'b1;
                                        OPL_WRDI:  d.wel = 1'b0;
                                        OPL_RDSR:  d.st = S_SOUT;
                                        OPL_WRSR:  d.st = S_SIN;
                                        OPL_READ:  d.st = S_RADDR;
                                        OPL_WRITE: d.st = S_WADDR;
                                        default:   d.st = S_SKIP;
                                    endcase
                                end
                            end
                        end
                        S_RADDR: begin
                            d.addr = mk_addr(q.hi, rx_nx);
                            d.st = S_RDATA;
                        end
                        S_WADDR: begin
                            d.addr = mk_addr(q.hi, rx_nx);
                            d.st = S_WDATA;
                        end
                        S_WDATA, S_SIN: begin
                            if (!q.got) begin
                                d.dat = rx_nx;
                                d.got = 1'b1;
                            end
                        end
                        default: d.st = q.st;
                    endcase
                end
            end else if (sck_fall && (q.st == S_RDATA || q.st == S_SOUT)) begin
                if (q.cnt == '0) begin
                    if (q.st == S_RDATA) begin
                        d.tx = rd_data;
                        d.addr = (q.addr == AW'(DEPTH - 1)) ? '0 : q.addr + 1'b1;
                    end else begin
                        d.tx = status;
                    end
                end else begin
                    d.tx = {q.tx[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, cs_p: 1'b1, sck_p: 1'b0, cnt: '0, sh: '0, tx: '0,
                   hi: 1'b0, addr: '0, dat: '0, got: 1'b0, wel: 1'b0, bp: '0, bcnt: '0};
        end else begin
            q <= d;
        end
    end

    assign rd_addr  = q.addr;
    assign waddr    = q.addr;
    assign wdata    = q.dat;
    assign miso_bit = q.tx[7];

    // R3
    wel_needs_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.wel) |-> $past(wp_s));

    // R9
    busy_end_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !q.wel);

    // R9
    write_starts_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> busy);

    // R7
    bp_change_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.bp) |-> $rose(busy));

    // R4
    release_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> (q.st == S_IDLE));
endmodule

// File: rtl/spi_eeprom_emu.sv
module spi_eeprom_emu #(
    parameter int DEPTH = 128,
    parameter int BUSY_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    output logic miso,
    input  logic wp_n
);
    localparam int AW = $clog2(DEPTH);

    logic [3:0]    pins_s;
    logic [AW-1:0] rd_addr, waddr;
    logic [7:0]    rd_data, wdata;
    logic          we, miso_bit;

    spi_ee_sync #(.W(4), .STAGES(2), .RST_VAL(4'b1001)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({wp_n, mosi, sclk, cs_n}),
        .dout (pins_s)
    );

    spi_ee_ctrl #(.DEPTH(DEPTH), .BUSY_CYCLES(BUSY_CYCLES), .AW(AW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_s    (pins_s[0]),
        .sck_s   (pins_s[1]),
        .mosi_s  (pins_s[2]),
        .wp_s    (pins_s[3]),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata),
        .miso_bit(miso_bit)
    );

    spi_ee_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (we),
        .waddr(waddr),
        .wdata(wdata),
        .raddr(rd_addr),
        .rdata(rd_data)
    );

    assign miso = cs_n ? 1'bz : miso_bit;
endmodule

// File: tb/spi_eeprom_emu_tb.sv
module spi_eeprom_emu_tb;
    localparam int DEPTH = 512;
    localparam int BUSY = 1500;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic mosi = 1'b0;
    logic wp_n = 1'b1;
    wire  miso;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] m_mem [DEPTH];
    logic       m_wel = 1'b0;
    logic [1:0] m_bp = 2'b00;
    logic [7:0] rbuf [8];

    always #5 clk = ~clk;

    spi_eeprom_emu #(.DEPTH(DEPTH), .BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .mosi(mosi), .miso(miso), .wp_n(wp_n)
    );

    function automatic logic f_prot(input logic [1:0] bp, input int a);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return a >= DEPTH - DEPTH / 4;
            2'b10:   return a >= DEPTH / 2;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] f_status(input logic busy);
        return {4'b0000, m_bp, m_wel, busy};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        @(negedge clk);
        cs_n = 1'b0;
        ticks(HALF);
    endtask

    task automatic desel();
        ticks(HALF);
        cs_n = 1'b1;
        ticks(HALF);
    endtask

    task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nb; i--) begin
            mosi = tx[i];
            ticks(HALF);
            sclk = 1'b1;
            rx[i] = miso;
            ticks(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
        xbits(tx, 8, rx);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        sel(); xb(op, r); desel();
    endtask

    task automatic rdsr(input logic [7:0] op, output logic [7:0] st);
        logic [7:0] r;
        sel(); xb(op, r); xb(8'h00, st); desel();
    endtask

    task automatic wr(input int a, input logic [7:0] v);
        logic [7:0] r;
        sel();
        xb(8'h02 | (8'(a >> 8) << 3), r);
        xb(8'(a), r);
        xb(v, r);
        desel();
    endtask

    task automatic rd(input int a, input int n);
        logic [7:0] r;
        sel();
        xb(8'h03 | (8'(a >> 8) << 3), r);
        xb(8'(a), r);
        for (int k = 0; k < n; k++) begin
            xb(8'h00, r);
            rbuf[k] = r;
        end
        desel();
    endtask

    task automatic wait_ready();
        ticks(BUSY + 40);
    endtask

    task automatic wren();
        cmd1(8'h06);
        if (wp_n) m_wel = 1'b1;
    endtask

    task automatic model_write(input int a, input logic [7:0] v);
        wren();
        wr(a, v);
        if (m_wel && !f_prot(m_bp, a)) begin
            m_mem[a] = v;
            wait_ready();
            m_wel = 1'b0;
        end
    endtask

    task automatic finish_up();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_up();
        end
    end

    initial begin
        logic [7:0] st, s2, r;
        int a;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
        ticks(5);
        rst_n = 1'b1;
        ticks(5);

        // R10: deselected output floats
        total++;
        if (miso !== 1'bz) begin
            bad++;
            $display("FAIL R10 actual=%b expected=z", miso);
        end

        // R1: reset status
        rdsr(8'h05, st); chk("R1 reset status", st, 8'h00);

        // R4: write without enable ignored
        wr(16, 8'h5A); wait_ready();
        rd(16, 1); chk("R4 write without latch", rbuf[0], 8'hFF);

        // R3: enable with wp_n low refused
        wp_n = 1'b0; cmd1(8'h06); wp_n = 1'b1;
        rdsr(8'h05, st); chk("R3 wren with wp low", st, 8'h00);

        // R2 and R3: enable with bit 3 set still decodes
        cmd1(8'h0E); m_wel = 1'b1;
        rdsr(8'h05, st); chk("R2 wren bit3 set", st, 8'h02);
        rdsr(8'h0D, st); chk("R2 rdsr bit3 set", st, 8'h02);

        // R2: opcode with upper bits set is ignored
        cmd1(8'h14);
        rdsr(8'h05, st); chk("R2 bad opcode ignored", st, 8'h02);

        // R3: disable works with wp_n low
        wp_n = 1'b0; cmd1(8'h04); wp_n = 1'b1; m_wel = 1'b0;
        rdsr(8'h05, st); chk("R3 wrdi with wp low", st, 8'h00);

        // R9: write starts busy, status shows busy and latch
        wren(); wr(16, 8'h5A); m_mem[16] = 8'h5A;
        rdsr(8'h05, st); chk("R9 busy during program", st, 8'h03);
        wr(32, 8'h77);
        wait_ready(); m_wel = 1'b0;
        rdsr(8'h05, st); chk("R9 busy end clears latch", st, 8'h00);
        rd(32, 1); chk("R9 write during busy ignored", rbuf[0], 8'hFF);
        rd(16, 1); chk("R5 read back", rbuf[0], 8'h5A);

        // R6: ninth address bit
        model_write(9'h1F0, 8'hA5);
        model_write(9'h0F0, 8'h3C);
        rd(9'h1F0, 1); chk("R6 upper page", rbuf[0], 8'hA5);
        rd(9'h0F0, 1); chk("R6 lower page", rbuf[0], 8'h3C);

        // R5: wrap at end of array
        model_write(DEPTH - 1, 8'h11);
        model_write(0, 8'h22);
        rd(DEPTH - 2, 4);
        chk("R5 wrap b0", rbuf[0], m_mem[DEPTH - 2]);
        chk("R5 wrap b1", rbuf[1], 8'h11);
        chk("R5 wrap b2", rbuf[2], 8'h22);
        chk("R5 wrap b3", rbuf[3], m_mem[1]);

        // R4: chip select released mid byte aborts the write
        wren();
        sel(); xb(8'h02, r); xb(8'h30, r); xbits(8'h99, 4, r); desel();
        rdsr(8'h05, st); chk("R4 aborted write status", st, 8'h02);
        rd(48, 1); chk("R4 aborted write data", rbuf[0], 8'hFF);

        // R7: status write sets protect bits
        sel(); xb(8'h01, r); xb(8'h04, r); desel();
        m_bp = 2'b01;
        rdsr(8'h05, st); chk("R7 wrsr busy", st, 8'h07);
        wait_ready(); m_wel = 1'b0;
        rdsr(8'h05, st); chk("R7 protect bits", st, 8'h04);

        // R8: top quarter protected
        wren(); wr(9'h180, 8'hEE);
        rdsr(8'h05, st); chk("R8 protected write keeps latch", st, 8'h06);
        wr(9'h17F, 8'hDD); m_mem[9'h17F] = 8'hDD;
        rdsr(8'h05, st); chk("R8 unprotected write busy", st, 8'h07);
        wait_ready(); m_wel = 1'b0;
        rd(9'h17F, 2);
        chk("R8 below boundary", rbuf[0], 8'hDD);
        chk("R8 at boundary", rbuf[1], 8'hFF);

        // R8: half protection
        wren(); sel(); xb(8'h01, r); xb(8'h08, r); desel();
        wait_ready(); m_bp = 2'b10; m_wel = 1'b0;
        model_write(9'h100, 8'h42);
        model_write(9'h0FF, 8'h43);
        rd(9'h0FF, 2);
        chk("R8 half lower", rbuf[0], 8'h43);
        chk("R8 half upper", rbuf[1], m_mem[9'h100]);
        wren(); sel(); xb(8'h01, r); xb(8'h00, r); desel();
        wait_ready(); m_bp = 2'b00; m_wel = 1'b0;

        // R11: repeated status bytes
        wren();
        sel(); xb(8'h05, r); xb(8'h00, st); xb(8'h00, s2); desel();
        chk("R11 status byte 1", st, 8'h02);
        chk("R11 status byte 2", s2, 8'h02);
        cmd1(8'h04); m_wel = 1'b0;

        // R4 R5: random writes and streamed reads against the model
        for (int n = 0; n < 20; n++) begin
            a = int'($urandom % DEPTH);
            model_write(a, 8'($urandom));
        end
        for (int n = 0; n < 8; n++) begin
            a = int'($urandom % DEPTH);
            rd(a, 3);
            for (int k = 0; k < 3; k++)
                chk("R5 random stream", rbuf[k], m_mem[(a + k) % DEPTH]);
        end

        total++;
        if (miso !== 1'bz) begin
            bad++;
            $display("FAIL R10 end actual=%b expected=z", miso);
        end
        finish_up();
    end
endmodule